// File: doc/BRIEF.md
# Non-Restoring Divider Sequencer

This block is the control unit of an N-bit non-restoring divider. It steps an external datapath, made of a partial-remainder accumulator register and a quotient register, through a fixed schedule. Once a start request arrives, it runs one initialisation cycle and one forced subtraction. It then alternates between shift/test cycles and add-or-subtract cycles, N/2 shift/test cycles in total. At the end it raises a one-cycle done flag and returns to waiting.

The add-or-subtract choice for the datapath adder is kept in a flip-flop. Only two steps reload it. The subtraction step forces "subtract". Each shift/test step chooses "subtract" when the remainder sign is non-negative and "add" when it is negative. Every other step leaves the choice unchanged, so the adder sees a steady control value for the whole operation. An internal counter tracks the shift/test steps: it is cleared in the initialisation cycle and advanced once in every shift/test cycle. All outputs are plain control levels decoded from the registered state. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `nrdiv_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `acc_en`, `quo_en`, `sub_sel` and `done` are all 0 and the sequencer is waiting.
- R2: While waiting with `start` low, no enable and no `done` is raised, for any number of cycles.
- R3: `start` high at a clock edge while waiting leads to one initialisation cycle with no enables, followed by one subtraction cycle.
- R4: In the subtraction cycle `acc_en` is 1 and `quo_en` is 0, and `sub_sel` reads 1 (subtract) from the next cycle.
- R5: In each shift/test cycle `quo_en` is 1 and `acc_en` is 0. In the next cycle `sub_sel` reads 1 if `rem_neg` was 0 during the shift/test cycle, and 0 (add) if it was 1.
- R6: Exactly N/2 shift/test cycles run per operation. Each one except the last is followed by a single add-or-subtract cycle with `acc_en` at 1, and then by the next shift/test cycle.
- R7: The cycle after the last shift/test cycle raises `done` for exactly one cycle, and the sequencer is waiting again in the cycle after that.
- R8: In the waiting, initialisation, add-or-subtract and done cycles, `sub_sel` keeps its value whatever `rem_neg` does.
- R9: At most one of `acc_en`, `quo_en` and `done` is high in any cycle.
- R10: If `start` stays high, a new operation begins immediately: the initialisation cycle follows the single waiting cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operation request, sampled while waiting |
| rem_neg | input | 1 | Sign of the partial remainder (1 = negative) |
| acc_en | output | 1 | Load enable of the accumulator register |
| quo_en | output | 1 | Shift enable of the quotient register |
| sub_sel | output | 1 | Adder control: 1 = subtract, 0 = add |
| done | output | 1 | One-cycle completion flag |

## Verification
The enables and `done` are decoded from the state register. Each one therefore appears in the cycle that follows the edge that moved the state: the initialisation cycle comes one cycle after `start` is sampled, the subtraction cycle two cycles after, and `done` 2+N cycles after. `sub_sel` passes through its own register, so a sign presented during a shift/test cycle shows up one cycle later, in the add-or-subtract or done cycle. The bench drives inputs and samples outputs on the falling edge. It walks the schedule one cycle at a time, with an expected select that it updates only after the cycle in which the requirement says the value changes. While it checks the cycles in which the select must hold, it drives the opposite sign value.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
  typedef enum logic [2:0] {
    ST_WAIT = 3'd0,
    ST_PREP = 3'd1,
    ST_SUB  = 3'd2,
    ST_TEST = 3'd3,
    ST_STEP = 3'd4,
    ST_DONE = 3'd5
  } ctrl_state_e;
endpackage

// File: rtl/nrdiv_iter_cnt.sv
module nrdiv_iter_cnt #(
  parameter int ITERS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(ITERS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (inc) cnt_q <= cnt_q + 1'b1;
  end

  // compared before the increment: the test visit with this value is the last
  assign last = (cnt_q == LAST_VAL);
endmodule

// File: rtl/nrdiv_sel_reg.sv
module nrdiv_sel_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic force_sub,
  input  logic from_sign,
  input  logic rem_neg,
  output logic sub_sel
);
  logic sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sel_q <= 1'b0;
    else if (force_sub) sel_q <= 1'b1;
    else if (from_sign) sel_q <= ~rem_neg;
  end

  assign sub_sel = sel_q;
endmodule

// File: rtl/nrdiv_ctrl_fsm.sv
module nrdiv_ctrl_fsm
  import nrdiv_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        last,
  output ctrl_state_e state,
  output logic        acc_en,
  output logic        quo_en,
  output logic        done,
  output logic        cnt_clr,
  output logic        cnt_inc,
  output logic        force_sub,
  output logic        from_sign
);
  ctrl_state_e st_q, st_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_WAIT;
    else        st_q <= st_d;
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_WAIT: if (start) st_d = ST_PREP;
      ST_PREP: st_d = ST_SUB;
      ST_SUB:  st_d = ST_TEST;
      ST_TEST: st_d = last ? ST_DONE : ST_STEP;
      ST_STEP: st_d = ST_TEST;
      ST_DONE: st_d = ST_WAIT;
      default: st_d = ST_WAIT;
    endcase
  end

  always_comb begin
    acc_en    = (st_q == ST_SUB) || (st_q == ST_STEP);
    quo_en    = (st_q == ST_TEST);
    done      = (st_q == ST_DONE);
    cnt_clr   = (st_q == ST_PREP);
    cnt_inc   = (st_q == ST_TEST);
    force_sub = (st_q == ST_SUB);
    from_sign = (st_q == ST_TEST);
  end

  assign state = st_q;
endmodule

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
  import nrdiv_pkg::*;
#(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rem_neg,
  output logic acc_en,
  output logic quo_en,
  output logic sub_sel,
  output logic done
);
  localparam int ITERS = (N / 2 > 0) ? N / 2 : 1;

  ctrl_state_e cur_st;
  logic last, cnt_clr, cnt_inc, force_sub, from_sign;

  nrdiv_ctrl_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .last(last),
    .state(cur_st), .acc_en(acc_en), .quo_en(quo_en), .done(done),
    .cnt_clr(cnt_clr), .cnt_inc(cnt_inc),
    .force_sub(force_sub), .from_sign(from_sign)
  );

  nrdiv_iter_cnt #(.ITERS(ITERS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .last(last)
  );

  nrdiv_sel_reg u_sel (
    .clk(clk), .rst_n(rst_n), .force_sub(force_sub),
    .from_sign(from_sign), .rem_neg(rem_neg), .sub_sel(sub_sel)
  );
endmodule

// File: rtl/nrdiv_ctrl_chk.sv
module nrdiv_ctrl_chk
  import nrdiv_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        rem_neg,
  input logic        acc_en,
  input logic        quo_en,
  input logic        sub_sel,
  input logic        done,
  input ctrl_state_e cur_st
);
  a_r9_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_en, quo_en, done}));

  a_r3_start_to_prep: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_WAIT && start) |=> (cur_st == ST_PREP));

  a_r3_prep_to_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_PREP) |=> (acc_en && cur_st == ST_SUB));

  a_r4_force_subtract: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_SUB) |=> sub_sel);

  a_r5_sign_choice: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_TEST) |=> (sub_sel == !$past(rem_neg)));

  a_r6_step_to_test: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_STEP) |=> quo_en);

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cur_st == ST_WAIT));

  a_r8_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st != ST_SUB && cur_st != ST_TEST) |=> $stable(sub_sel));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_st == ST_WAIT && !start) |=> (!acc_en && !quo_en && !done));
endmodule

bind nrdiv_ctrl nrdiv_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rem_neg(rem_neg),
  .acc_en(acc_en), .quo_en(quo_en), .sub_sel(sub_sel), .done(done),
  .cur_st(cur_st)
);

// File: tb/test_nrdiv_ctrl.sv
`timescale 1ns/1ps
module test_nrdiv_ctrl;
  localparam int N = 8;
  localparam int ITERS = N / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rem_neg = 1'b0;
  logic acc_en, quo_en, sub_sel, done;

  int n_chk = 0;
  int n_err = 0;
  logic exp_sel = 1'b0;

  always #2 clk = ~clk;

  nrdiv_ctrl #(.N(N)) i_nrdiv_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .rem_neg(rem_neg),
    .acc_en(acc_en), .quo_en(quo_en), .sub_sel(sub_sel), .done(done)
  );

  // expected vector order: {acc_en, quo_en, sub_sel, done}
  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {acc_en, quo_en, sub_sel, done};
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0; start = 1'b0;
    #1 chk("R1 in reset", 4'b0000);
    @(negedge clk) rst_n = 1'b1;
    exp_sel = 1'b0;
    @(negedge clk) chk("R1 after reset", 4'b0000);
  endtask

  task automatic t_idle_quiet();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) rem_neg = i[0];
      chk("R2 idle no action / R8 sel held", {2'b00, exp_sel, 1'b0});
    end
  endtask

  // one full operation with a given sign per shift/test cycle
  task automatic t_run(input logic [ITERS-1:0] signs);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0; rem_neg = ~rem_neg;
    chk("R3 prep cycle", {2'b00, exp_sel, 1'b0});
    @(negedge clk) rem_neg = ~rem_neg;
    chk("R4 subtract cycle", {2'b10, exp_sel, 1'b0});
    exp_sel = 1'b1;
    for (int i = 0; i < ITERS; i++) begin
      @(negedge clk) rem_neg = signs[i];
      chk("R5 test cycle", {2'b01, exp_sel, 1'b0});
      exp_sel = ~signs[i];
      @(negedge clk) rem_neg = signs[i];
      if (i < ITERS - 1) chk("R6 step cycle / R5 choice", {2'b10, exp_sel, 1'b0});
      else               chk("R7 done cycle / R5 choice", {2'b00, exp_sel, 1'b1});
      rem_neg = ~signs[i];
    end
    @(negedge clk) rem_neg = ~rem_neg;
    chk("R7 back to waiting / R8 held", {2'b00, exp_sel, 1'b0});
  endtask

  // start held high: second operation follows the single waiting cycle
  task automatic t_back_to_back();
    @(negedge clk) start = 1'b1; rem_neg = 1'b0;
    for (int c = 1; c <= 2 * ITERS + 5; c++) begin
      @(negedge clk);
      if (c == 2 * ITERS + 2) chk("R10 done of first run", {2'b00, 1'b1, 1'b1});
      if (c == 2 * ITERS + 3) chk("R10 single waiting cycle", {2'b00, 1'b1, 1'b0});
      if (c == 2 * ITERS + 4) chk("R10 prep of second run", {2'b00, 1'b1, 1'b0});
      if (c == 2 * ITERS + 5) chk("R10 subtract of second run", {2'b10, 1'b1, 1'b0});
    end
    start = 1'b0;
  endtask

  task automatic t_reset_midrun();
    @(negedge clk) start = 1'b1; rem_neg = 1'b1;
    @(negedge clk) start = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R6 step before reset", {2'b10, 1'b0, 1'b0});
    rst_n = 1'b0;
    #1 chk("R1 reset mid-run", 4'b0000);
    @(negedge clk) rst_n = 1'b1; exp_sel = 1'b0;
    @(negedge clk) chk("R1 waiting after reset", 4'b0000);
    @(negedge clk) chk("R2 still waiting", 4'b0000);
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    do_reset();
    t_idle_quiet();
    t_run(4'b0000);
    t_run(4'b1111);
    t_run(4'b0101);
    t_run(4'b1001);
    t_idle_quiet();
    do_reset();
    t_back_to_back();
    do_reset();
    t_reset_midrun();
    t_run(4'b0110);
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule